// File: doc/BRIEF.md
# Multicast Label Translation Tables

This block translates connection labels for a small cell switch that carries multicast traffic. Translation happens in two places. On the ingress side, the 24-bit label of an arriving cell header (an 8-bit path field followed by a 16-bit channel field) is matched against an associative table. A hit returns a one-bit-per-output bitmap that tells the fabric where to copy the cell. The label and the other header bits pass through unchanged. A miss drops the cell and raises a miss flag.

Each output port has its own egress table. The lookup key joins the number of the input port the copy came from with the copy's old label. A hit swaps the label for the new label stored in the entry. A miss drops that copy and pulses an error line for that port. Because the key includes the source port, two connections that merge onto one output with equal labels still translate independently.

Connection setup and teardown use per-table write ports. A write puts an entry into the first free slot, or overwrites the entry whose key already matches. A delete clears the valid bit of the matching entry. Every lookup stream uses a valid/ready handshake and returns its result one cycle after the cell is accepted.

Top module: `mcast_label_xlate`

## Requirements
- R1: During and right after reset, all tables are empty. No output is valid, no miss or error flag is set, and every input ready is high.
- R2: An ingress cell whose label has a valid entry is presented one cycle after acceptance. It carries the stored 4-bit port bitmap (bit p means output p), and its label and other header bits are unchanged.
- R3: An ingress cell with no matching entry produces no output. `ig_miss` is high for exactly the one cycle after acceptance.
- R4: An egress copy whose key {source port, old label} has a valid entry on that port is presented one cycle after acceptance. It carries the stored new label, and its other header bits are unchanged.
- R5: On one output port, equal old labels arriving from different source ports translate to the distinct new labels written for each source.
- R6: An egress copy with no matching entry produces no output. Its port's `eg_err` bit is high for exactly the one cycle after acceptance.
- R7: Writing a key that is already present replaces that entry's data and adds no second entry. One delete then removes the key, and this holds even when the table is full.
- R8: A delete makes later lookups of that key miss. Other entries are not affected.
- R9: A write or delete issued in the same cycle as a lookup of the same key is not seen by that lookup. It applies from the next cycle.
- R10: While an output is valid and its ready is low, the output holds its values, its input ready is low, and no new cell is accepted.
- R11: A write of a new key to a table that already holds 16 valid entries is ignored. The existing entries stay intact.
- R12: Egress tables are per port. A write selected for one output port never changes lookups on another port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ig_valid | input | 1 | Ingress cell header valid |
| ig_ready | output | 1 | Ingress stage can accept |
| ig_label | input | 24 | Ingress cell label |
| ig_misc | input | 8 | Other ingress header bits |
| igo_valid | output | 1 | Ingress result valid |
| igo_ready | input | 1 | Downstream accepts ingress result |
| igo_label | output | 24 | Label passed through |
| igo_misc | output | 8 | Header bits passed through |
| igo_ports | output | 4 | Copy bitmap, bit p = output p |
| ig_miss | output | 1 | Ingress lookup miss pulse |
| it_we | input | 1 | Ingress table write |
| it_del | input | 1 | Ingress table delete (wins over write) |
| it_label | input | 24 | Ingress table key |
| it_ports | input | 4 | Ingress table bitmap data |
| eg_valid | input | 4 | Egress copy valid, one per port |
| eg_ready | output | 4 | Egress stage can accept, per port |
| eg_src | input | 8 | Source port per output, 2 bits each |
| eg_label | input | 96 | Old label per output, 24 bits each |
| eg_misc | input | 32 | Other header bits per output |
| ego_valid | output | 4 | Egress result valid, per port |
| ego_ready | input | 4 | Downstream accepts egress result |
| ego_label | output | 96 | New label per port |
| ego_misc | output | 32 | Header bits passed through |
| eg_err | output | 4 | Egress lookup miss pulse, per port |
| et_we | input | 1 | Egress table write |
| et_del | input | 1 | Egress table delete (wins over write) |
| et_port | input | 2 | Output port whose table is written |
| et_src | input | 2 | Key: source port |
| et_old | input | 24 | Key: old label |
| et_new | input | 24 | Data: new label |

## Verification
A stale or duplicated table entry shows up on the next lookup of the affected key. It appears as a wrong bitmap or label, or as a miss or error pulse where a hit was expected, one cycle after acceptance. A table that cannot find free slots, or one that writes the wrong slot, causes a full-table fill to lose entries, and this is seen when early and late entries are read back. A broken handshake register shows up within a stalled cycle as a changing held output or a high ready. A key that drops the source field shows up in the first lookup of two merged connections.

// File: rtl/mcl_pkg.sv
package mcl_pkg;
  localparam int unsigned MCL_PORTS   = 4;
  localparam int unsigned MCL_LABEL_W = 24;
  localparam int unsigned MCL_MISC_W  = 8;
  localparam int unsigned MCL_DEPTH   = 16;
endpackage

// File: rtl/mcl_cam.sv
module mcl_cam #(
  parameter int unsigned KW    = 24,
  parameter int unsigned DW    = 4,
  parameter int unsigned DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          del_en,
  input  logic [KW-1:0] wr_key,
  input  logic [DW-1:0] wr_data,
  input  logic [KW-1:0] lk_key,
  output logic          lk_hit,
  output logic [DW-1:0] lk_data
);
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [KW-1:0]    key_q [DEPTH];
  logic [DW-1:0]    dat_q [DEPTH];
  logic [DEPTH-1:0] vld_q;

  logic          w_hit, f_any, do_wr;
  logic [IW-1:0] w_idx, f_idx, slot;

  // lookup port: at most one valid entry can match a key
  always_comb begin
    lk_hit  = 1'b0;
    lk_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld_q[i] && key_q[i] == lk_key) begin
        lk_hit  = 1'b1;
        lk_data = dat_q[i];
      end
    end
  end

  // write port: find a matching slot, else the lowest free slot
  always_comb begin
    w_hit = 1'b0;
    w_idx = '0;
    f_any = 1'b0;
    f_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (vld_q[i] && key_q[i] == wr_key) begin
        w_hit = 1'b1;
        w_idx = IW'(i);
      end
      if (!vld_q[i]) begin
        f_any = 1'b1;
        f_idx = IW'(i);
      end
    end
  end

  assign slot  = w_hit ? w_idx : f_idx;
  assign do_wr = wr_en && !del_en && (w_hit || f_any);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else if (del_en && w_hit) begin
      vld_q[w_idx] <= 1'b0;
    end else if (do_wr) begin
      vld_q[slot] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) begin
      key_q[slot] <= wr_key;
      dat_q[slot] <= wr_data;
    end
  end
endmodule

// File: rtl/mcl_stage.sv
module mcl_stage #(
  parameter int unsigned KW    = 24,
  parameter int unsigned DW    = 4,
  parameter int unsigned XW    = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [KW-1:0] in_key,
  input  logic [XW-1:0] in_pass,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic [XW-1:0] out_pass,
  output logic          miss,
  input  logic          tw_en,
  input  logic          td_en,
  input  logic [KW-1:0] t_key,
  input  logic [DW-1:0] t_data
);
  logic          hit;
  logic [DW-1:0] hit_data;
  logic          accept;

  mcl_cam #(.KW(KW), .DW(DW), .DEPTH(DEPTH)) u_cam (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (tw_en),
    .del_en  (td_en),
    .wr_key  (t_key),
    .wr_data (t_data),
    .lk_key  (in_key),
    .lk_hit  (hit),
    .lk_data (hit_data)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_pass  <= '0;
      miss      <= 1'b0;
    end else begin
      miss <= accept && !hit;
      if (accept) begin
        out_valid <= hit;
        out_data  <= hit_data;
        out_pass  <= in_pass;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mcast_label_xlate.sv
module mcast_label_xlate
  import mcl_pkg::*;
#(
  parameter int unsigned NP    = MCL_PORTS,
  parameter int unsigned LW    = MCL_LABEL_W,
  parameter int unsigned OW    = MCL_MISC_W,
  parameter int unsigned DEPTH = MCL_DEPTH,
  parameter int unsigned PW    = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ig_valid,
  output logic           ig_ready,
  input  logic [LW-1:0]  ig_label,
  input  logic [OW-1:0]  ig_misc,
  output logic           igo_valid,
  input  logic           igo_ready,
  output logic [LW-1:0]  igo_label,
  output logic [OW-1:0]  igo_misc,
  output logic [NP-1:0]  igo_ports,
  output logic           ig_miss,
  input  logic           it_we,
  input  logic           it_del,
  input  logic [LW-1:0]  it_label,
  input  logic [NP-1:0]  it_ports,
  input  logic [NP-1:0]  eg_valid,
  output logic [NP-1:0]  eg_ready,
  input  logic [NP*PW-1:0] eg_src,
  input  logic [NP*LW-1:0] eg_label,
  input  logic [NP*OW-1:0] eg_misc,
  output logic [NP-1:0]  ego_valid,
  input  logic [NP-1:0]  ego_ready,
  output logic [NP*LW-1:0] ego_label,
  output logic [NP*OW-1:0] ego_misc,
  output logic [NP-1:0]  eg_err,
  input  logic           et_we,
  input  logic           et_del,
  input  logic [PW-1:0]  et_port,
  input  logic [PW-1:0]  et_src,
  input  logic [LW-1:0]  et_old,
  input  logic [LW-1:0]  et_new
);
  localparam int unsigned EKW = PW + LW;

  // ingress: label -> copy bitmap, label and header bits carried along
  mcl_stage #(.KW(LW), .DW(NP), .XW(LW + OW), .DEPTH(DEPTH)) u_ing (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (ig_valid),
    .in_ready  (ig_ready),
    .in_key    (ig_label),
    .in_pass   ({ig_label, ig_misc}),
    .out_valid (igo_valid),
    .out_ready (igo_ready),
    .out_data  (igo_ports),
    .out_pass  ({igo_label, igo_misc}),
    .miss      (ig_miss),
    .tw_en     (it_we),
    .td_en     (it_del),
    .t_key     (it_label),
    .t_data    (it_ports)
  );

  // egress: one table per output, key {source port, old label}
  for (genvar p = 0; p < NP; p++) begin : g_eg
    logic sel;
    assign sel = (et_port == PW'(p));

    mcl_stage #(.KW(EKW), .DW(LW), .XW(OW), .DEPTH(DEPTH)) u_egr (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (eg_valid[p]),
      .in_ready  (eg_ready[p]),
      .in_key    ({eg_src[p*PW +: PW], eg_label[p*LW +: LW]}),
      .in_pass   (eg_misc[p*OW +: OW]),
      .out_valid (ego_valid[p]),
      .out_ready (ego_ready[p]),
      .out_data  (ego_label[p*LW +: LW]),
      .out_pass  (ego_misc[p*OW +: OW]),
      .miss      (eg_err[p]),
      .tw_en     (et_we && sel),
      .td_en     (et_del && sel),
      .t_key     ({et_src, et_old}),
      .t_data    (et_new)
    );
  end
endmodule

// File: rtl/mcl_chk.sv
module mcl_chk #(
  parameter int unsigned NP = 4,
  parameter int unsigned LW = 24
) (
  input logic            clk,
  input logic            rst,
  input logic            ig_valid,
  input logic            ig_ready,
  input logic            igo_valid,
  input logic            igo_ready,
  input logic [LW-1:0]   igo_label,
  input logic [NP-1:0]   igo_ports,
  input logic            ig_miss,
  input logic [NP-1:0]   eg_valid,
  input logic [NP-1:0]   eg_ready,
  input logic [NP-1:0]   ego_valid,
  input logic [NP-1:0]   ego_ready,
  input logic [NP*LW-1:0] ego_label,
  input logic [NP-1:0]   eg_err
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $fell(rst) |-> !igo_valid && !ig_miss && ego_valid == '0 && eg_err == '0);

  // R3
  ig_miss_cause_chk: assert property (@(posedge clk) disable iff (rst)
    ig_miss |-> $past(ig_valid && ig_ready));

  // R3
  ig_miss_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ig_miss && igo_valid));

  // R10
  ig_hold_chk: assert property (@(posedge clk) disable iff (rst)
    igo_valid && !igo_ready |=> igo_valid && $stable(igo_label) && $stable(igo_ports));

  for (genvar p = 0; p < NP; p++) begin : g_pc
    // R6
    eg_err_cause_chk: assert property (@(posedge clk) disable iff (rst)
      eg_err[p] |-> $past(eg_valid[p] && eg_ready[p]));

    // R10
    eg_hold_chk: assert property (@(posedge clk) disable iff (rst)
      ego_valid[p] && !ego_ready[p] |=> ego_valid[p] && $stable(ego_label[p*LW +: LW]));
  end
endmodule

bind mcast_label_xlate mcl_chk #(.NP(NP), .LW(LW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ig_valid  (ig_valid),
  .ig_ready  (ig_ready),
  .igo_valid (igo_valid),
  .igo_ready (igo_ready),
  .igo_label (igo_label),
  .igo_ports (igo_ports),
  .ig_miss   (ig_miss),
  .eg_valid  (eg_valid),
  .eg_ready  (eg_ready),
  .ego_valid (ego_valid),
  .ego_ready (ego_ready),
  .ego_label (ego_label),
  .eg_err    (eg_err)
);

// File: tb/mcast_label_xlate_tb.sv
`timescale 1ns/1ps
module mcast_label_xlate_tb;
  localparam int NP = 4, LW = 24, OW = 8, PW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ig_valid = 0, igo_ready = 1, it_we = 0, it_del = 0;
  logic [LW-1:0] ig_label = '0, it_label = '0;
  logic [OW-1:0] ig_misc = '0;
  logic [NP-1:0] it_ports = '0;
  logic [NP-1:0] eg_valid = '0, ego_ready = '1;
  logic [NP*PW-1:0] eg_src = '0;
  logic [NP*LW-1:0] eg_label = '0;
  logic [NP*OW-1:0] eg_misc = '0;
  logic et_we = 0, et_del = 0;
  logic [PW-1:0] et_port = '0, et_src = '0;
  logic [LW-1:0] et_old = '0, et_new = '0;

  logic ig_ready, igo_valid, ig_miss;
  logic [LW-1:0] igo_label;
  logic [OW-1:0] igo_misc;
  logic [NP-1:0] igo_ports, eg_ready, ego_valid, eg_err;
  logic [NP*LW-1:0] ego_label;
  logic [NP*OW-1:0] ego_misc;

  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  mcast_label_xlate u_dut (
    .clk(clk), .rst(rst),
    .ig_valid(ig_valid), .ig_ready(ig_ready), .ig_label(ig_label), .ig_misc(ig_misc),
    .igo_valid(igo_valid), .igo_ready(igo_ready), .igo_label(igo_label),
    .igo_misc(igo_misc), .igo_ports(igo_ports), .ig_miss(ig_miss),
    .it_we(it_we), .it_del(it_del), .it_label(it_label), .it_ports(it_ports),
    .eg_valid(eg_valid), .eg_ready(eg_ready), .eg_src(eg_src), .eg_label(eg_label),
    .eg_misc(eg_misc), .ego_valid(ego_valid), .ego_ready(ego_ready),
    .ego_label(ego_label), .ego_misc(ego_misc), .eg_err(eg_err),
    .et_we(et_we), .et_del(et_del), .et_port(et_port), .et_src(et_src),
    .et_old(et_old), .et_new(et_new)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // table access, one cycle each, driven on the falling edge
  task automatic it_write(logic [LW-1:0] lab, logic [NP-1:0] bm, logic del);
    it_we = !del; it_del = del; it_label = lab; it_ports = bm;
    @(negedge clk);
    it_we = 0; it_del = 0;
  endtask

  task automatic et_write(int p, int s, logic [LW-1:0] o, logic [LW-1:0] n, logic del);
    et_we = !del; et_del = del; et_port = PW'(p); et_src = PW'(s); et_old = o; et_new = n;
    @(negedge clk);
    et_we = 0; et_del = 0;
  endtask

  // lookups: result is visible at the falling edge after acceptance
  task automatic ig_look(logic [LW-1:0] lab, logic [OW-1:0] m);
    ig_valid = 1; ig_label = lab; ig_misc = m;
    @(negedge clk);
    ig_valid = 0;
  endtask

  task automatic eg_look(int p, int s, logic [LW-1:0] lab, logic [OW-1:0] m);
    eg_valid[p] = 1'b1;
    eg_src[p*PW +: PW] = PW'(s);
    eg_label[p*LW +: LW] = lab;
    eg_misc[p*OW +: OW] = m;
    @(negedge clk);
    eg_valid[p] = 1'b0;
  endtask

  task automatic eg_expect(string req, int p, logic hit, logic [LW-1:0] n);
    check(req, ego_valid[p], hit);
    check(req, eg_err[p], !hit);
    if (hit) check(req, ego_label[p*LW +: LW], n);
  endtask

  task automatic t_reset();
    check("R1", igo_valid, 0);
    check("R1", ig_miss, 0);
    check("R1", ig_ready, 1);
    check("R1", ego_valid, 0);
    check("R1", eg_err, 0);
    check("R1", eg_ready, 4'hf);
    ig_look(24'h01_0042, 8'h11);
    check("R1 empty ingress", ig_miss, 1);
  endtask

  task automatic t_ig_hit();
    it_write(24'h0A_1234, 4'b1011, 0);
    ig_look(24'h0A_1234, 8'h5A);
    check("R2 valid", igo_valid, 1);
    check("R2 bitmap", igo_ports, 4'b1011);
    check("R2 label", igo_label, 24'h0A_1234);
    check("R2 misc", igo_misc, 8'h5A);
  endtask

  task automatic t_ig_miss();
    ig_look(24'h0B_0001, 8'h01);
    check("R3 no output", igo_valid, 0);
    check("R3 miss", ig_miss, 1);
    @(negedge clk);
    check("R3 single pulse", ig_miss, 0);
  endtask

  task automatic t_eg_hit();
    et_write(1, 2, 24'h0A_1234, 24'h3C_0F0F, 0);
    eg_look(1, 2, 24'h0A_1234, 8'hC3);
    eg_expect("R4", 1, 1, 24'h3C_0F0F);
    check("R4 misc", ego_misc[1*OW +: OW], 8'hC3);
  endtask

  task automatic t_eg_merge();
    et_write(1, 3, 24'h0A_1234, 24'h44_5566, 0);
    eg_look(1, 3, 24'h0A_1234, 8'h00);
    eg_expect("R5 src3", 1, 1, 24'h44_5566);
    eg_look(1, 2, 24'h0A_1234, 8'h00);
    eg_expect("R5 src2", 1, 1, 24'h3C_0F0F);
  endtask

  task automatic t_eg_miss();
    eg_look(1, 0, 24'h0A_1234, 8'h00);
    eg_expect("R6", 1, 0, '0);
    @(negedge clk);
    check("R6 single pulse", eg_err[1], 0);
  endtask

  task automatic t_overwrite();
    it_write(24'h0A_1234, 4'b0100, 0);
    ig_look(24'h0A_1234, 8'h00);
    check("R7 new data", igo_ports, 4'b0100);
    it_write(24'h0A_1234, '0, 1);
    ig_look(24'h0A_1234, 8'h00);
    check("R7 no duplicate", ig_miss, 1);
    check("R7 no duplicate", igo_valid, 0);
  endtask

  task automatic t_delete();
    et_write(1, 2, 24'h0A_1234, '0, 1);
    eg_look(1, 2, 24'h0A_1234, 8'h00);
    eg_expect("R8 deleted", 1, 0, '0);
    eg_look(1, 3, 24'h0A_1234, 8'h00);
    eg_expect("R8 neighbour kept", 1, 1, 24'h44_5566);
  endtask

  task automatic t_same_cycle();
    it_we = 1; it_label = 24'h0C_0C0C; it_ports = 4'b0011;
    ig_valid = 1; ig_label = 24'h0C_0C0C;
    @(negedge clk);
    it_we = 0;
    check("R9 write unseen", ig_miss, 1);
    @(negedge clk);
    ig_valid = 0;
    check("R9 write applied", igo_valid, 1);
    check("R9 write applied", igo_ports, 4'b0011);
    it_del = 1; it_label = 24'h0C_0C0C;
    ig_valid = 1;
    @(negedge clk);
    it_del = 0; ig_valid = 0;
    check("R9 delete unseen", igo_valid, 1);
    ig_look(24'h0C_0C0C, 8'h00);
    check("R9 delete applied", ig_miss, 1);
  endtask

  task automatic t_backpressure();
    it_write(24'h0D_00D0, 4'b1000, 0);
    igo_ready = 0;
    ig_valid = 1; ig_label = 24'h0D_00D0; ig_misc = 8'h77;
    @(negedge clk);
    check("R10 captured", igo_valid, 1);
    ig_label = 24'h0E_00E0; ig_misc = 8'h99;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      check("R10 held valid", igo_valid, 1);
      check("R10 held data", {igo_ports, igo_label, igo_misc}, {4'b1000, 24'h0D_00D0, 8'h77});
      check("R10 stalled", ig_ready, 0);
      check("R10 no accept", ig_miss, 0);
    end
    igo_ready = 1;
    @(negedge clk);
    ig_valid = 0;
    check("R10 drained", igo_valid, 0);
    check("R10 next accepted", ig_miss, 1);
  endtask

  task automatic t_full();
    for (int i = 0; i < 16; i++) et_write(3, 0, 24'h10_0000 + LW'(i), 24'h20_0000 + LW'(i), 0);
    et_write(3, 0, 24'h1F_FFFF, 24'hAB_CDEF, 0);
    eg_look(3, 0, 24'h1F_FFFF, 8'h00);
    eg_expect("R11 full write ignored", 3, 0, '0);
    eg_look(3, 0, 24'h10_0000, 8'h00);
    eg_expect("R11 first kept", 3, 1, 24'h20_0000);
    eg_look(3, 0, 24'h10_000F, 8'h00);
    eg_expect("R11 last kept", 3, 1, 24'h20_000F);
    et_write(3, 0, 24'h10_0005, 24'h55_5555, 0);
    eg_look(3, 0, 24'h10_0005, 8'h00);
    eg_expect("R7 overwrite when full", 3, 1, 24'h55_5555);
  endtask

  task automatic t_ports_indep();
    eg_look(0, 3, 24'h0A_1234, 8'h00);
    eg_expect("R12 port0", 0, 0, '0);
    eg_look(2, 0, 24'h10_0000, 8'h00);
    eg_expect("R12 port2", 2, 0, '0);
    eg_look(1, 3, 24'h0A_1234, 8'h00);
    eg_expect("R12 port1", 1, 1, 24'h44_5566);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    @(negedge clk);
    t_ig_hit();
    t_ig_miss();
    t_eg_hit();
    t_eg_merge();
    t_eg_miss();
    t_overwrite();
    t_delete();
    t_same_cycle();
    t_backpressure();
    t_full();
    t_ports_indep();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end
endmodule